// File: doc/BRIEF.md
# Frequency Hopping Carrier Word Sequencer

This block drives the carrier selection of a hopping FSK transmitter. It keeps a small table of precomputed carrier frequency words and, at the end of every dwell interval, jumps to a new table entry picked by a pseudorandom generator. The selected word is held on `carrier_word` for a whole dwell and is summed with the data deviation word further down the transmit path, which is where the oscillator and the data modulation live.

Three things are programmable while the block runs: the table contents, the dwell length in clock cycles, and the seed of the pseudorandom generator. Changes to the table and to the dwell length never disturb the dwell in progress. They are picked up at the next hop. A single enable input pauses the whole sequence.

Top module: `hop_word_sequencer`

## Requirements
- R1: While reset is asserted, `carrier_word` and `chan_idx` are zero and `hop_strobe` is low. After reset the generator state is `RESET_SEED`, and both the dwell counter and the dwell register hold `DWELL_INIT`.
- R2: The dwell counter counts down once per enabled cycle. `hop_strobe` is high for exactly the cycles in which `enable` is high and the counter is zero. At that edge the counter reloads, so with a dwell value D hops are D+1 enabled cycles apart. D = 0 gives a hop on every enabled cycle.
- R3: At each hop the 16-bit generator moves one step: new = {old[14:0], old[15]^old[14]^old[12]^old[3]}. `chan_idx` becomes the low `IDX_W` bits of the new state, and `carrier_word` becomes the table entry at that index. Both show the new value in the cycle after the strobe.
- R4: `carrier_word` and `chan_idx` change only in the cycle after a hop strobe.
- R5: A table write (`tbl_wr_en`, `tbl_wr_addr`, `tbl_wr_data`) never changes the output during a dwell. It is seen by the next hop that selects that entry. A write in the same cycle as a hop to the entry being selected takes effect only for later hops.
- R6: A dwell write (`dwell_wr_en`, `dwell_wr_val`) does not change the count in progress. It is used at the next reload. A write in a hop cycle applies from the reload after that one.
- R7: A seed write loads the generator at the next edge, replacing a zero value with 1. It takes priority over a step in the same cycle, although that hop still presents the successor of the old state. The next hop steps from the loaded seed.
- R8: While `enable` is low, the counter and the generator hold, no strobe is raised and the outputs hold. Table, dwell and seed writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the dwell counter and the sequence when high |
| tbl_wr_en | input | 1 | Table entry write strobe |
| tbl_wr_addr | input | IDX_W | Table entry to write |
| tbl_wr_data | input | WORD_W | Carrier word to store |
| dwell_wr_en | input | 1 | Dwell register write strobe |
| dwell_wr_val | input | DWELL_W | New dwell value (hop period minus one) |
| seed_wr_en | input | 1 | Generator seed load strobe |
| seed_wr_val | input | 16 | Seed value; zero is loaded as 1 |
| hop_strobe | output | 1 | One cycle per hop |
| chan_idx | output | IDX_W | Index of the current table entry |
| carrier_word | output | WORD_W | Current carrier base word |

## Verification
The assertions take the write strobes to be free to arrive in any cycle, including hop cycles and cycles with enable low. They rely on only two things: a synchronous reset, and a dwell write value that fits `DWELL_W`. The stimulus mixes random writes at random rates with directed cases that place a seed load and a write to the entry being selected on the exact hop edge. It also runs a zero dwell and a seed of zero. The random dwell values stay small so that many hops fall within the run.

// File: rtl/hop_seq_pkg.sv
package hop_seq_pkg;
  localparam int LFSR_W = 16;
  // feedback positions 16,15,13,4 (1-based) as a bit mask
  localparam logic [LFSR_W-1:0] LFSR_TAP_MASK = 16'hD008;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & LFSR_TAP_MASK)};
  endfunction

  function automatic logic [LFSR_W-1:0] seed_sanitize(input logic [LFSR_W-1:0] s);
    return (s == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : s;
  endfunction
endpackage

// File: rtl/hop_lfsr.sv
module hop_lfsr
  import hop_seq_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RESET_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [LFSR_W-1:0] load_val,
  output logic [LFSR_W-1:0] state,
  output logic [LFSR_W-1:0] succ
);
  assign succ = lfsr_step(state);

  always_ff @(posedge clk) begin
    if (!rst_n)       state <= seed_sanitize(RESET_SEED);
    else if (load)    state <= seed_sanitize(load_val);
    else if (advance) state <= succ;
  end

  p_state_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  p_zero_seed_fix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> state == 16'd1);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !load) |=> $stable(state));
  p_step_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> state != $past(state));
endmodule

// File: rtl/hop_dwell_timer.sv
module hop_dwell_timer #(
  parameter int              DWELL_W    = 24,
  parameter logic [DWELL_W-1:0] DWELL_INIT = 24'd7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [DWELL_W-1:0] reload_val,
  output logic               hop,
  output logic [DWELL_W-1:0] count
);
  logic at_zero;
  assign at_zero = (count == '0);
  assign hop     = enable && at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= DWELL_INIT;
    else if (hop)    count <= reload_val;
    else if (enable) count <= count - 1'b1;
  end

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hop |=> count == $past(reload_val));
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && count != '0) |=> count == $past(count) - 1'b1);
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count));
endmodule

// File: rtl/hop_word_table.sv
module hop_word_table #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] entry [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_addr == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   entry[g] <= '0;
      else if (sel) entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_addr];
endmodule

// File: rtl/hop_word_sequencer.sv
module hop_word_sequencer
  import hop_seq_pkg::*;
#(
  parameter int                 WORD_W     = 32,
  parameter int                 IDX_W      = 4,
  parameter int                 DWELL_W    = 24,
  parameter logic [DWELL_W-1:0] DWELL_INIT = 24'd7,
  parameter logic [LFSR_W-1:0]  RESET_SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_addr,
  input  logic [WORD_W-1:0]  tbl_wr_data,
  input  logic               dwell_wr_en,
  input  logic [DWELL_W-1:0] dwell_wr_val,
  input  logic               seed_wr_en,
  input  logic [LFSR_W-1:0]  seed_wr_val,
  output logic               hop_strobe,
  output logic [IDX_W-1:0]   chan_idx,
  output logic [WORD_W-1:0]  carrier_word
);
  // named internal events
  logic               hop_evt;
  logic [LFSR_W-1:0]  lfsr_state;
  logic [LFSR_W-1:0]  lfsr_succ;
  logic [IDX_W-1:0]   next_idx;
  logic [WORD_W-1:0]  next_word;
  logic [DWELL_W-1:0] dwell_cfg;
  logic [DWELL_W-1:0] dwell_count;

  always_ff @(posedge clk) begin
    if (!rst_n)           dwell_cfg <= DWELL_INIT;
    else if (dwell_wr_en) dwell_cfg <= dwell_wr_val;
  end

  hop_dwell_timer #(.DWELL_W(DWELL_W), .DWELL_INIT(DWELL_INIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .reload_val(dwell_cfg), .hop(hop_evt), .count(dwell_count)
  );

  hop_lfsr #(.RESET_SEED(RESET_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(hop_evt),
    .load(seed_wr_en), .load_val(seed_wr_val),
    .state(lfsr_state), .succ(lfsr_succ)
  );

  assign next_idx = lfsr_succ[IDX_W-1:0];

  hop_word_table #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
    .rd_addr(next_idx), .rd_data(next_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_idx     <= '0;
      carrier_word <= '0;
    end else if (hop_evt) begin
      chan_idx     <= next_idx;
      carrier_word <= next_word;
    end
  end

  assign hop_strobe = hop_evt;

  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_evt |=> ($stable(carrier_word) && $stable(chan_idx)));
  p_idx_follows_lfsr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hop_evt |=> chan_idx == $past(lfsr_succ[IDX_W-1:0]));
  p_no_strobe_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !hop_strobe);
  p_strobe_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hop_strobe |-> dwell_count == '0);
endmodule

// File: tb/sim_hop_word_sequencer.sv
module sim_hop_word_sequencer;
  localparam int WORD_W = 32;
  localparam int IDX_W = 4;
  localparam int DWELL_W = 24;
  localparam logic [23:0] DWELL_INIT = 24'd7;
  localparam logic [15:0] RESET_SEED = 16'hACE1;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tbl_wr_en = 1'b0;
  logic [IDX_W-1:0] tbl_wr_addr = '0;
  logic [WORD_W-1:0] tbl_wr_data = '0;
  logic dwell_wr_en = 1'b0;
  logic [DWELL_W-1:0] dwell_wr_val = '0;
  logic seed_wr_en = 1'b0;
  logic [15:0] seed_wr_val = '0;
  logic hop_strobe;
  logic [IDX_W-1:0] chan_idx;
  logic [WORD_W-1:0] carrier_word;

  always #10 clk = ~clk;

  hop_word_sequencer #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .DWELL_W(DWELL_W),
    .DWELL_INIT(DWELL_INIT), .RESET_SEED(RESET_SEED)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
    .dwell_wr_en(dwell_wr_en), .dwell_wr_val(dwell_wr_val),
    .seed_wr_en(seed_wr_en), .seed_wr_val(seed_wr_val),
    .hop_strobe(hop_strobe), .chan_idx(chan_idx), .carrier_word(carrier_word)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  string phase = "init";

  // reference model state
  logic [WORD_W-1:0] m_tbl [16];
  logic [15:0] m_lfsr;
  logic [23:0] m_cnt, m_dwell;
  logic [WORD_W-1:0] m_word;
  logic [IDX_W-1:0] m_idx;

  function automatic logic [15:0] ref_next(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    return {s[14:0], fb};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s [%s]: actual %h expected %h", tag, phase, act, exp);
    end
  endtask

  // called just after a falling edge: check, drive, advance the model
  task automatic tick(input bit en, input bit twr, input logic [3:0] ta,
                      input logic [31:0] td, input bit dwr, input logic [23:0] dv,
                      input bit swr, input logic [15:0] sv);
    logic hop;
    logic [15:0] nl;
    chk("R2 strobe", {31'd0, hop_strobe}, {31'd0, (enable && m_cnt == 24'd0)});
    chk("R3 R4 word", carrier_word, m_word);
    chk("R3 R4 index", {28'd0, chan_idx}, {28'd0, m_idx});
    enable = en; tbl_wr_en = twr; tbl_wr_addr = ta; tbl_wr_data = td;
    dwell_wr_en = dwr; dwell_wr_val = dv; seed_wr_en = swr; seed_wr_val = sv;
    hop = en && (m_cnt == 24'd0);
    nl = ref_next(m_lfsr);
    if (hop) begin
      m_word = m_tbl[nl[3:0]];
      m_idx = nl[3:0];
      m_cnt = m_dwell;
    end else if (en) begin
      m_cnt = m_cnt - 24'd1;
    end
    if (swr) m_lfsr = (sv == 16'd0) ? 16'd1 : sv;
    else if (hop) m_lfsr = nl;
    if (twr) m_tbl[ta] = td;
    if (dwr) m_dwell = dv;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit en);
    for (int i = 0; i < n; i++) tick(en, 0, '0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    chk("R1 word", carrier_word, 32'd0);
    chk("R1 index", {28'd0, chan_idx}, 32'd0);
    chk("R1 strobe", {31'd0, hop_strobe}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) m_tbl[i] = '0;
    m_lfsr = RESET_SEED; m_cnt = DWELL_INIT; m_dwell = DWELL_INIT;
    m_word = '0; m_idx = '0;
    @(negedge clk);

    phase = "R8 writes while frozen";
    for (int i = 0; i < 16; i++)
      tick(0, 1, 4'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, 0, '0, 0, '0);
    run(10, 0);

    phase = "R2 R3 default dwell";
    run(40, 1);

    phase = "R6 dwell write mid-dwell";
    tick(1, 0, '0, '0, 1, 24'd2, 0, '0);
    run(30, 1);

    phase = "R5 table write mid-dwell";
    for (int i = 0; i < 16; i++)
      tick(1, 1, 4'(i), $urandom, 0, '0, 0, '0);
    run(20, 1);

    phase = "R5 write on hop edge to selected entry";
    while (m_cnt != 24'd0) tick(1, 0, '0, '0, 0, '0, 0, '0);
    tick(1, 1, ref_next(m_lfsr) & 16'h000F, 32'hDEAD_BEEF, 0, '0, 0, '0);
    run(20, 1);

    phase = "R7 zero seed";
    tick(1, 0, '0, '0, 0, '0, 1, 16'd0);
    run(12, 1);

    phase = "R7 seed on hop edge";
    while (m_cnt != 24'd0) tick(1, 0, '0, '0, 0, '0, 0, '0);
    tick(1, 0, '0, '0, 0, '0, 1, 16'h1234);
    run(12, 1);

    phase = "R6 dwell write on hop edge";
    while (m_cnt != 24'd0) tick(1, 0, '0, '0, 0, '0, 0, '0);
    tick(1, 0, '0, '0, 1, 24'd0, 0, '0);
    phase = "R2 zero dwell";
    run(25, 1);

    phase = "R8 enable low mid-dwell";
    tick(1, 0, '0, '0, 1, 24'd5, 0, '0);
    run(3, 1);
    tick(0, 1, 4'd3, 32'h5555_AAAA, 0, '0, 1, 16'hBEEF);
    run(20, 0);
    run(20, 1);

    phase = "random";
    for (int i = 0; i < 5000; i++) begin
      bit en, twr, dwr, swr;
      logic [15:0] sv;
      en  = ($urandom_range(0, 9) != 0);
      twr = ($urandom_range(0, 4) == 0);
      dwr = ($urandom_range(0, 29) == 0);
      swr = ($urandom_range(0, 49) == 0);
      sv  = ($urandom_range(0, 3) == 0) ? 16'd0 : 16'($urandom);
      tick(en, twr, 4'($urandom), $urandom, dwr, 24'($urandom_range(0, 12)), swr, sv);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule